// File: doc/BRIEF.md
# Second-Generation Link Stall Recovery Monitor

This block sits beside a PCI Express root port and watches the controller's 64-bit debug status for one failure: a speed change from the first to the second generation that has stalled. The link is down, training sits in the receiver-lock recovery state, and the PHY receiver reports no valid data. When the monitor sees the stall, it resets the PHY receiver. It reads the PHY receive-override register, sets the data-enable and PLL-enable override bits, and writes the value back. It keeps the override in place for a fixed number of timebase ticks, then reads the register again, clears both bits and writes it back.

All PHY traffic goes through a request/done handshake to a PHY register access port, which lies outside this block. An error on any access aborts the recovery and sets a sticky fault flag. After each recovery, whether it completed or was aborted, the monitor waits for a programmable number of ticks before it looks at the stall condition again. A counter reports how many override pulses have completed.

Top module: `gen2_stall_recover`

## Requirements
- R1: While the link is up (bit 4 of `dbg_hi` set), the monitor starts no PHY access and no recovery.
- R2: The stall condition is `dbg_lo[5:0]` == 6'h0D with the link down. On this condition the monitor reads PHY address 16'h100D. It goes on with recovery only if bit 0 of the returned data is 0 and the condition still holds. Otherwise it returns to idle without writing.
- R3: Recovery reads PHY address 16'h1005 and writes back the returned value OR 16'h0028 (bit 5 for receive data enable, bit 3 for receive PLL enable), leaving every other bit unchanged.
- R4: After the setting write, the monitor waits HOLD_TICKS timebase ticks (default 3, which gives a 2 to 3 ms pulse with a 1 ms tick). It then reads 16'h1005 again and writes back the value AND NOT 16'h0028.
- R5: A request (`phy_req` high) keeps `phy_we`, `phy_addr` and `phy_wdata` steady until the cycle in which `phy_done` is high, and is then taken down or replaced by the next access.
- R6: When `phy_done` and `phy_err` are both high, the monitor abandons the recovery with no further write in that attempt, and `fault` goes to 1 and stays at 1 until reset.
- R7: After a recovery ends, the monitor starts no new PHY access until `holdoff_ticks` timebase ticks have passed.
- R8: `recov_count` goes up by exactly 1 when the clearing write completes without error, and changes at no other time.
- R9: Under synchronous active-low reset, `phy_req`, `fault` and `recov_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_lo | input | 32 | Lower debug status word; bits 5:0 hold the training state |
| dbg_hi | input | 32 | Upper debug status word; bit 4 is link up |
| tick | input | 1 | One-cycle timebase pulse |
| holdoff_ticks | input | TMR_W | Ticks to wait after a recovery before watching again |
| phy_req | output | 1 | PHY access request, held until done |
| phy_we | output | 1 | 1 = write, 0 = read |
| phy_addr | output | 16 | PHY register address |
| phy_wdata | output | 16 | Write data |
| phy_rdata | input | 16 | Read data, valid with phy_done |
| phy_done | input | 1 | Access complete, one-cycle pulse |
| phy_err | input | 1 | Access failed, valid with phy_done |
| recov_count | output | CNT_W | Number of completed override pulses |
| fault | output | 1 | Sticky access-error flag |

## Verification
The bench covers several decoy patterns that must not trigger recovery: the stall code with the link-up bit set, a neighbouring training state, and a receiver that reports valid data. A design that decodes the wrong bits, or ignores one of these qualifiers, would write the override register in these cases. Patterns with all the unused debug bits set check that the decode masks them out. Override values with other bits already set check that the read-modify-write keeps those bits; a design that writes a constant would lose them. The bench also measures two timings. The gap between the setting and clearing writes must last the hold time, and the gap after a recovery must last the holdoff; a design that skips either timer shows a gap of a few cycles. An error injected on the override read must leave the flag set and must produce no write. A flag that is not sticky, or an abort that does not take effect, shows up here.

// File: rtl/lrm_pkg.sv
// Shared constants and state encoding for the stall recovery monitor.
// Assumes 16-bit PHY register addresses and data.
package lrm_pkg;
    localparam logic [15:0] RXSTAT_ADDR = 16'h100D;
    localparam logic [15:0] OVRD_ADDR   = 16'h1005;
    localparam logic [15:0] OVRD_MASK   = 16'h0028;
    localparam logic [5:0]  STALL_CODE  = 6'h0D;
    localparam int          LINK_BIT    = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PROBE,
        S_GET_SET,
        S_PUT_SET,
        S_HOLD,
        S_GET_CLR,
        S_PUT_CLR,
        S_REST
    } lrm_state_e;
endpackage

// File: rtl/lrm_stall_decode.sv
// Decodes link-up and the stall training state from the debug words.
// Pure combinational logic; the caller registers what it needs.
module lrm_stall_decode
    import lrm_pkg::*;
(
    input  logic [31:0] dbg_lo,
    input  logic [31:0] dbg_hi,
    output logic        link_up,
    output logic        stalled
);
    logic unused_dbg;

    // Pick out the link bit and compare the training state with the stall code.
    always_comb begin
        link_up    = dbg_hi[LINK_BIT];
        stalled    = !dbg_hi[LINK_BIT] && (dbg_lo[5:0] == STALL_CODE);
        unused_dbg = ^{dbg_lo[31:6], dbg_hi[31:5], dbg_hi[3:0]};
    end
endmodule

// File: rtl/lrm_tick_timer.sv
// Counts timebase ticks from a start pulse; expired rises once limit ticks
// have been seen. Assumes limit is stable while the count runs.
module lrm_tick_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tick,
    input  logic [TMR_W-1:0] limit,
    output logic             expired
);
    logic             busy;
    logic [TMR_W-1:0] cnt;

    assign expired = busy && (cnt >= limit);

    // Load on start, then advance on each tick until the limit is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy && tick && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/gen2_stall_recover.sv
// Watches debug status for a stalled second-generation speed change and
// pulses the PHY receiver override bits through a read-modify-write.
// Assumes the access port holds phy_done high for one cycle per request,
// with phy_rdata and phy_err valid in that cycle.
module gen2_stall_recover
    import lrm_pkg::*;
#(
    parameter int HOLD_TICKS = 3,
    parameter int TMR_W      = 8,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      dbg_lo,
    input  logic [31:0]      dbg_hi,
    input  logic             tick,
    input  logic [TMR_W-1:0] holdoff_ticks,
    output logic             phy_req,
    output logic             phy_we,
    output logic [15:0]      phy_addr,
    output logic [15:0]      phy_wdata,
    input  logic [15:0]      phy_rdata,
    input  logic             phy_done,
    input  logic             phy_err,
    output logic [CNT_W-1:0] recov_count,
    output logic             fault
);
    localparam logic [TMR_W-1:0] HOLD_LIM = TMR_W'(HOLD_TICKS);

    lrm_state_e       st, nxt;
    logic             link_up, stalled;
    logic             tmr_start, tmr_done;
    logic [TMR_W-1:0] tmr_limit;
    logic [15:0]      wbuf;
    logic             ok_done, bad_done;

    lrm_stall_decode u_dec (
        .dbg_lo  (dbg_lo),
        .dbg_hi  (dbg_hi),
        .link_up (link_up),
        .stalled (stalled)
    );

    lrm_tick_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .tick    (tick),
        .limit   (tmr_limit),
        .expired (tmr_done)
    );

    assign ok_done  = phy_done && !phy_err;
    assign bad_done = phy_done && phy_err;

    // Next-state decision for the recovery sequence.
    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE:    if (stalled) nxt = S_PROBE;
            S_PROBE:   if (bad_done) nxt = S_REST;
                       else if (ok_done) nxt = (!phy_rdata[0] && stalled) ? S_GET_SET : S_IDLE;
            S_GET_SET: if (bad_done) nxt = S_REST; else if (ok_done) nxt = S_PUT_SET;
            S_PUT_SET: if (bad_done) nxt = S_REST; else if (ok_done) nxt = S_HOLD;
            S_HOLD:    if (tmr_done) nxt = S_GET_CLR;
            S_GET_CLR: if (bad_done) nxt = S_REST; else if (ok_done) nxt = S_PUT_CLR;
            S_PUT_CLR: if (phy_done) nxt = S_REST;
            S_REST:    if (tmr_done) nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // Timer is loaded on entry to the hold or holdoff states.
    always_comb begin
        tmr_start = (nxt != st) && (nxt == S_HOLD || nxt == S_REST);
        tmr_limit = (st == S_HOLD) ? HOLD_LIM : holdoff_ticks;
    end

    // Access port drive, derived from the current state.
    always_comb begin
        phy_req   = (st == S_PROBE) || (st == S_GET_SET) || (st == S_PUT_SET) ||
                    (st == S_GET_CLR) || (st == S_PUT_CLR);
        phy_we    = (st == S_PUT_SET) || (st == S_PUT_CLR);
        phy_addr  = (st == S_PROBE) ? RXSTAT_ADDR : OVRD_ADDR;
        phy_wdata = wbuf;
    end

    // State, write buffer, recovery counter and sticky fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= S_IDLE;
            wbuf        <= '0;
            recov_count <= '0;
            fault       <= 1'b0;
        end else begin
            st <= nxt;
            if (st == S_GET_SET && ok_done) wbuf <= phy_rdata | OVRD_MASK;
            if (st == S_GET_CLR && ok_done) wbuf <= phy_rdata & ~OVRD_MASK;
            if (st == S_PUT_CLR && ok_done) recov_count <= recov_count + 1'b1;
            if (bad_done) fault <= 1'b1;
        end
    end

    // R1: an idle monitor with the link up issues no request next cycle.
    p_quiet_link_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && link_up) |=> !phy_req);

    // R3: the setting write always carries both override bits.
    p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && phy_we && st == S_PUT_SET) |-> ((phy_wdata & OVRD_MASK) == OVRD_MASK));

    // R4: the clearing write carries neither override bit.
    p_clr_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && phy_we && st == S_PUT_CLR) |-> ((phy_wdata & OVRD_MASK) == 16'h0000));

    // R5: a pending request keeps its fields steady.
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && !phy_done) |=> (phy_req && $stable(phy_we) && $stable(phy_addr) && $stable(phy_wdata)));

    // R6: the fault flag never falls outside reset.
    p_fault_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);

    // R8: the counter moves only after a clean clearing write.
    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (recov_count != $past(recov_count)) |-> ($past(st == S_PUT_CLR && phy_done && !phy_err)
            && recov_count == $past(recov_count) + 1'b1));
endmodule

// File: tb/test_gen2_stall_recover.sv
module test_gen2_stall_recover;
    localparam int CLK_P  = 10;
    localparam int TICK_P = 10;
    localparam int LAT    = 2;
    localparam int NV     = 7;

    // Vector table: debug words, rx-valid bit, initial override, expectations.
    localparam logic [31:0] T_LO  [NV] = '{32'h0000000D, 32'h0000000D, 32'h0000000D,
                                           32'h0000000C, 32'h0000000D, 32'hFFFFFFCD, 32'h0000000D};
    localparam logic [31:0] T_HI  [NV] = '{32'h0, 32'h0, 32'h00000010, 32'h0, 32'h0,
                                           32'hFFFFFFEF, 32'h0};
    localparam logic        T_RXV [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
    localparam logic [15:0] T_OVR [NV] = '{16'h0000, 16'hFFFF, 16'h0000, 16'h0000,
                                           16'h0000, 16'h1234, 16'h00A0};
    localparam logic        T_REC [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
    localparam logic        T_PRB [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
    localparam logic [15:0] T_W1  [NV] = '{16'h0028, 16'hFFFF, 16'h0, 16'h0, 16'h0,
                                           16'h123C, 16'h00A8};
    localparam logic [15:0] T_END [NV] = '{16'h0000, 16'hFFD7, 16'h0000, 16'h0000,
                                           16'h0000, 16'h1214, 16'h0080};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] dbg_lo = '0, dbg_hi = '0;
    logic        tick = 1'b0;
    logic [7:0]  holdoff_ticks = 8'd2;
    logic        phy_req, phy_we, phy_done, phy_err, fault;
    logic [15:0] phy_addr, phy_wdata, phy_rdata;
    logic [7:0]  recov_count;

    // PHY model state
    logic [15:0] ovr_mem = '0;
    logic        rxv = 1'b0;
    logic        inj_en = 1'b0;
    int          lat = 0;
    int          wr_cnt = 0;
    int          probe_cnt = 0;
    int          cyc = 0;
    int          w_val [64];
    int          w_cyc [64];
    int          total = 0, bad = 0;
    logic        ended = 1'b0;

    gen2_stall_recover i_gen2_stall_recover (
        .clk(clk), .rst_n(rst_n), .dbg_lo(dbg_lo), .dbg_hi(dbg_hi), .tick(tick),
        .holdoff_ticks(holdoff_ticks), .phy_req(phy_req), .phy_we(phy_we),
        .phy_addr(phy_addr), .phy_wdata(phy_wdata), .phy_rdata(phy_rdata),
        .phy_done(phy_done), .phy_err(phy_err), .recov_count(recov_count), .fault(fault)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        cyc  <= cyc + 1;
        tick <= ((cyc % TICK_P) == TICK_P - 1);
    end

    // PHY access port model with fixed latency and optional error on 0x1005 reads
    always @(posedge clk) begin
        if (!rst_n) begin
            phy_done <= 1'b0; phy_err <= 1'b0; lat <= 0; phy_rdata <= '0;
        end else begin
            phy_done <= 1'b0; phy_err <= 1'b0;
            if (phy_req && !phy_done) begin
                if (lat == LAT) begin
                    lat <= 0;
                    phy_done <= 1'b1;
                    if (phy_we) begin
                        if (phy_addr == 16'h1005) ovr_mem <= phy_wdata;
                        w_val[wr_cnt % 64] <= int'(phy_wdata);
                        w_cyc[wr_cnt % 64] <= cyc;
                        wr_cnt <= wr_cnt + 1;
                    end else begin
                        if (phy_addr == 16'h100D) probe_cnt <= probe_cnt + 1;
                        phy_rdata <= (phy_addr == 16'h100D) ? {15'b0, rxv} : ovr_mem;
                        phy_err   <= inj_en && (phy_addr == 16'h1005);
                    end
                end else begin
                    lat <= lat + 1;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_count_change(input logic [7:0] base, input int maxc);
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (recov_count != base) break;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!ended) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int base_w, base_p, gap, t0;
        logic [7:0] base_c;
        repeat (3) @(negedge clk);
        // R9: reset values
        chk("R9 req", phy_req, 1'b0);
        chk("R9 count", recov_count, 8'd0);
        chk("R9 fault", fault, 1'b0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // Table walk: R1 R2 R3 R4 R8
        for (int v = 0; v < NV; v++) begin
            ovr_mem = T_OVR[v]; rxv = T_RXV[v];
            base_w = wr_cnt; base_c = recov_count; base_p = probe_cnt;
            dbg_lo = T_LO[v]; dbg_hi = T_HI[v];
            if (T_REC[v]) begin
                wait_count_change(base_c, 400);
                dbg_lo = 32'h0;
                repeat (60) @(negedge clk);
                chk("R8 count step", recov_count, base_c + 8'd1);
                chk("R3 set write", w_val[base_w % 64], 32'(T_W1[v]));
                chk("R4 clear value", ovr_mem, T_END[v]);
                chk("R4 two writes", wr_cnt - base_w, 2);
                gap = w_cyc[(base_w + 1) % 64] - w_cyc[base_w % 64];
                chk("R4 hold length", (gap >= 20 && gap <= 50), 1'b1);
            end else begin
                repeat (150) @(negedge clk);
                dbg_lo = 32'h0;
                repeat (60) @(negedge clk);
                chk("R1/R2 no recovery", recov_count, base_c);
                chk("R1 R2 no write", wr_cnt - base_w, 0);
                chk("R2 override kept", ovr_mem, T_OVR[v]);
            end
            chk("R2 probe read", (probe_cnt != base_p), T_PRB[v]);
            dbg_hi = 32'h0;
        end

        // R6: error on the override read aborts and sets a sticky fault
        ovr_mem = 16'h0000; rxv = 1'b0; inj_en = 1'b1;
        base_w = wr_cnt; base_c = recov_count;
        dbg_lo = 32'h0000000D;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (fault) break;
        end
        dbg_lo = 32'h0; inj_en = 1'b0;
        repeat (60) @(negedge clk);
        chk("R6 fault set", fault, 1'b1);
        chk("R6 no write after error", wr_cnt - base_w, 0);
        chk("R6 no count", recov_count, base_c);
        // a later clean recovery leaves the fault set
        base_c = recov_count;
        dbg_lo = 32'h0000000D;
        wait_count_change(base_c, 400);
        dbg_lo = 32'h0;
        repeat (60) @(negedge clk);
        chk("R8 count after fault", recov_count, base_c + 8'd1);
        chk("R6 fault sticky", fault, 1'b1);

        // R7: holdoff gap between recovery end and next probe
        holdoff_ticks = 8'd5;
        base_c = recov_count;
        dbg_lo = 32'h0000000D;
        wait_count_change(base_c, 400);
        t0 = cyc;
        gap = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (phy_req && !phy_we && phy_addr == 16'h100D) begin
                gap = cyc - t0;
                break;
            end
        end
        dbg_lo = 32'h0;
        chk("R7 holdoff respected", (gap >= 40), 1'b1);
        repeat (80) @(negedge clk);
        chk("R5 port idle after sequence", phy_req, 1'b0);

        // R9: reset clears counter and fault
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 count cleared", recov_count, 8'd0);
        chk("R9 fault cleared", fault, 1'b0);
        chk("R9 req low", phy_req, 1'b0);

        ended = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule